// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns a bank of synchronised GPIO input levels into interrupt status. Each pin has its own control bits. They choose level or edge detection, the active polarity, an any-transition mode and an optional debounce filter. They also set an enable and a mask. The register block that owns these control vectors drives them straight into this block. It reads back the raw and masked status vectors and sends a one-cycle end-of-interrupt pulse with a write-1-to-clear vector.

Edge-detected pins latch their status until software clears it. Level-detected pins follow the filtered input on every cycle. A per-pin debounce stage runs from a slow tick and accepts a new level only after that level has been seen on two consecutive ticks. A single registered interrupt line is the OR of all masked status bits.

Top module: `gpio_irq_detect`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `raw_sts_o`, `msk_sts_o` and `irq_o` are all zero.
- R2: A pin with `edge_sel_i` bit 0 is level-detected. Its raw bit equals the filtered pin level when `pol_i` is 1 and its inverse when `pol_i` is 0. The raw bit updates one clock after the input, and `any_edge_i` has no effect on it.
- R3: A pin with `edge_sel_i` bit 1 is edge-detected. With `pol_i` 1 a 0-to-1 transition sets its raw bit, and with `pol_i` 0 a 1-to-0 transition sets it. The opposite transition does not set it, and a set bit stays set while the pin is held.
- R4: In edge mode, an `any_edge_i` bit of 1 makes the pin set its raw bit on both transitions, whatever its `pol_i` bit.
- R5: A cycle with `eoi_i` high clears every latched edge status bit whose `eoi_vec_i` bit is 1. Bits whose `eoi_vec_i` bit is 0 keep their value, and `eoi_vec_i` has no effect while `eoi_i` is low.
- R6: When a new qualifying edge and a clear for the same pin arrive in the same cycle, the raw bit is set after that cycle.
- R7: `msk_sts_o` equals raw status AND `irq_en_i` AND NOT `irq_mask_i`, registered one cycle after the raw status. A mask bit of 1 suppresses the pin.
- R8: A pin whose `irq_en_i` bit is 0 never shows in `msk_sts_o` or `irq_o`, even while its raw bit is set.
- R9: `irq_o` is the OR of all masked status bits and changes in the same cycle as `msk_sts_o`.
- R10: With `deb_en_i` set, a pin's filtered level changes only on a `deb_tick_i` cycle, and only when the pin held the new level on that tick and on the tick before it. A level that lasts for one tick only is rejected.
- R11: With `deb_en_i` clear, the pin level reaches detection directly, so the raw bit reacts one clock after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl_i | input | N_PINS | Synchronised pin levels |
| irq_en_i | input | N_PINS | Per-pin interrupt enable |
| irq_mask_i | input | N_PINS | Per-pin mask, 1 suppresses |
| edge_sel_i | input | N_PINS | 1 edge detection, 0 level detection |
| pol_i | input | N_PINS | 1 rising/high, 0 falling/low |
| any_edge_i | input | N_PINS | Edge mode: fire on both transitions |
| deb_en_i | input | N_PINS | Per-pin debounce enable |
| deb_tick_i | input | 1 | Slow debounce sampling strobe |
| eoi_i | input | 1 | End-of-interrupt write pulse |
| eoi_vec_i | input | N_PINS | Write-1-to-clear vector |
| raw_sts_o | output | N_PINS | Raw status |
| msk_sts_o | output | N_PINS | Masked status |
| irq_o | output | 1 | Combined interrupt line |

## Verification
On every cycle, the embedded assertions check four things. Latched edge bits survive until a clear. Level pins without debounce track the input. Masked status never shows a pin that is disabled, masked or raw-clear, and the interrupt line agrees with the masked vector. The debounce output holds between ticks. The directed scenarios are needed for the rest. They show which transition sets an edge pin under each polarity and under the any-edge bit, and they show that a simultaneous edge and clear leaves the bit set. They also show the two-tick acceptance of a debounced level, the rejection of a glitch, and the exact latency of each output.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned DEF_PINS = 32;

  typedef enum logic {
    DET_LEVEL = 1'b0,
    DET_EDGE  = 1'b1
  } det_kind_e;

  // Qualify a transition against polarity and the any-edge override.
  function automatic logic edge_hit(input logic rise, input logic fall,
                                    input logic pol, input logic any_edge);
    if (any_edge) return rise | fall;
    return pol ? rise : fall;
  endfunction

endpackage

// File: rtl/gpio_deb_filter.sv
module gpio_deb_filter (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic en_i,
  input  logic din_i,
  output logic dout_o
);
  logic smp_q;
  logic flt_q;

  // A level is accepted when the current tick sees the value of the last tick.
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= 1'b0;
      flt_q <= 1'b0;
    end else if (tick_i) begin
      smp_q <= din_i;
      if (din_i == smp_q) flt_q <= din_i;
    end
  end

  assign dout_o = en_i ? flt_q : din_i;

  AST_DEB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(flt_q)); // R10

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      filt_i,
  input  det_kind_e kind_i,
  input  logic      pol_i,
  input  logic      any_edge_i,
  input  logic      clr_i,
  output logic      raw_o
);
  logic prev_q;
  logic rise, fall, hit, raw_d;

  always_comb begin
    rise = filt_i & ~prev_q;
    fall = ~filt_i & prev_q;
    hit  = edge_hit(rise, fall, pol_i, any_edge_i);
    case (kind_i)
      DET_EDGE: raw_d = hit | (raw_o & ~clr_i);
      default:  raw_d = filt_i ~^ pol_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      raw_o  <= 1'b0;
    end else begin
      prev_q <= filt_i;
      raw_o  <= raw_d;
    end
  end

  AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
    (kind_i == DET_EDGE && raw_o && !clr_i) |=> raw_o); // R5

endmodule

// File: rtl/gpio_sts_combine.sv
module gpio_sts_combine #(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] raw_i,
  input  logic [N_PINS-1:0] en_i,
  input  logic [N_PINS-1:0] mask_i,
  output logic [N_PINS-1:0] msk_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] gated;

  assign gated = raw_i & en_i & ~mask_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      msk_o <= '0;
      irq_o <= 1'b0;
    end else begin
      msk_o <= gated;
      irq_o <= |gated;
    end
  end

  AST_IRQ_OR: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|msk_o)); // R9
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (rst)
    (msk_o & ~$past(en_i & ~mask_i)) == '0); // R8
  AST_MASK_RAW: assert property (@(posedge clk) disable iff (rst)
    (msk_o & ~$past(raw_i)) == '0); // R7

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = DEF_PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_lvl_i,
  input  logic [N_PINS-1:0] irq_en_i,
  input  logic [N_PINS-1:0] irq_mask_i,
  input  logic [N_PINS-1:0] edge_sel_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic [N_PINS-1:0] any_edge_i,
  input  logic [N_PINS-1:0] deb_en_i,
  input  logic              deb_tick_i,
  input  logic              eoi_i,
  input  logic [N_PINS-1:0] eoi_vec_i,
  output logic [N_PINS-1:0] raw_sts_o,
  output logic [N_PINS-1:0] msk_sts_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] filt;
  logic [N_PINS-1:0] clr;

  assign clr = eoi_vec_i & {N_PINS{eoi_i}};

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    gpio_deb_filter u_deb (
      .clk    (clk),
      .rst    (rst),
      .tick_i (deb_tick_i),
      .en_i   (deb_en_i[g]),
      .din_i  (pin_lvl_i[g]),
      .dout_o (filt[g])
    );

    gpio_pin_detect u_det (
      .clk        (clk),
      .rst        (rst),
      .filt_i     (filt[g]),
      .kind_i     (det_kind_e'(edge_sel_i[g])),
      .pol_i      (pol_i[g]),
      .any_edge_i (any_edge_i[g]),
      .clr_i      (clr[g]),
      .raw_o      (raw_sts_o[g])
    );
  end

  gpio_sts_combine #(.N_PINS(N_PINS)) u_comb (
    .clk    (clk),
    .rst    (rst),
    .raw_i  (raw_sts_o),
    .en_i   (irq_en_i),
    .mask_i (irq_mask_i),
    .msk_o  (msk_sts_o),
    .irq_o  (irq_o)
  );

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ((raw_sts_o ^ $past(pin_lvl_i ~^ pol_i))
     & $past(~edge_sel_i & ~deb_en_i) & {N_PINS{!$past(rst)}}) == '0); // R2

endmodule

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
  localparam int N = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic [N-1:0] pin, en, irqm, edg, pol, any, deb, eoi_vec;
  logic eoi, tick;
  logic [N-1:0] raw, msk;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gpio_irq_detect #(.N_PINS(N)) dut (
    .clk(clk), .rst(rst), .pin_lvl_i(pin), .irq_en_i(en), .irq_mask_i(irqm),
    .edge_sel_i(edg), .pol_i(pol), .any_edge_i(any), .deb_en_i(deb),
    .deb_tick_i(tick), .eoi_i(eoi), .eoi_vec_i(eoi_vec),
    .raw_sts_o(raw), .msk_sts_o(msk), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic clear_all();
    eoi = 1'b1; eoi_vec = '1; step(); eoi = 1'b0; eoi_vec = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1; pin = '0; en = '1; irqm = '0; edg = '0; pol = '0;
    any = '0; deb = '0; eoi = 1'b0; eoi_vec = '0; tick = 1'b0;
    step(3);
    chk("R1 raw in reset", raw, '0);
    chk("R1 masked in reset", msk, '0);
    chk("R1 irq in reset", {31'd0, irq}, '0);
    edg = '1; pol = '1;
    rst = 1'b0;
    step();
    chk("R1 raw after reset", raw, '0);
    chk("R1 irq after reset", {31'd0, irq}, '0);
    step();
  endtask

  task automatic t_level();
    edg[3:0] = 4'h0; pol[3:0] = 4'b0011; any[3] = 1'b1; pin[3:0] = 4'b0101;
    step();
    chk("R2 level pattern A", raw, 32'h9);
    pin[3:0] = 4'b1010;
    step();
    chk("R2 level pattern B", raw, 32'h6);
    pin[3:0] = 4'h0;
    step();
    edg[3:0] = 4'hf; pol[3:0] = 4'hf; any[3] = 1'b0;
    clear_all();
    chk("R5 clear all", raw, '0);
    step();
  endtask

  task automatic t_edge();
    pol[9] = 1'b0;
    step();
    pin[8] = 1'b1; pin[9] = 1'b1;
    step();
    chk("R3 R11 rising latches only pol1 pin", raw, 32'h100);
    step(3);
    chk("R3 latched while held", raw, 32'h100);
    pin[8] = 1'b0; pin[9] = 1'b0;
    step();
    chk("R3 falling latches pol0 pin", raw, 32'h300);
    step();
    chk("R7 masked follows raw", msk, 32'h300);
    chk("R9 irq high", {31'd0, irq}, 32'h1);
  endtask

  task automatic t_eoi();
    eoi = 1'b1; eoi_vec = 32'h100;
    step();
    eoi = 1'b0;
    chk("R5 selective clear", raw, 32'h200);
    eoi_vec = 32'h200;
    step();
    chk("R5 vector ignored without pulse", raw, 32'h200);
    eoi = 1'b1;
    step();
    eoi = 1'b0; eoi_vec = '0;
    chk("R5 second clear", raw, '0);
    step();
    chk("R9 masked cleared", msk, '0);
    chk("R9 irq low", {31'd0, irq}, '0);
    pol[9] = 1'b1;
  endtask

  task automatic t_both();
    any[12] = 1'b1; any[13] = 1'b1; pol[13] = 1'b0;
    pin[12] = 1'b1;
    step();
    chk("R4 any-edge rising", raw, 32'h1000);
    clear_all();
    pin[12] = 1'b0;
    step();
    chk("R4 any-edge falling with pol1", raw, 32'h1000);
    pin[13] = 1'b1;
    step();
    chk("R4 any-edge rising with pol0", raw, 32'h3000);
    pin[13] = 1'b0;
    step();
    any[12] = 1'b0; any[13] = 1'b0; pol[13] = 1'b1;
    clear_all();
    step();
  endtask

  task automatic t_race();
    pin[16] = 1'b1; eoi = 1'b1; eoi_vec = 32'h1_0000;
    step();
    eoi = 1'b0; eoi_vec = '0;
    chk("R6 edge beats clear", raw, 32'h1_0000);
    clear_all();
    chk("R5 clear after race", raw, '0);
    step();
  endtask

  task automatic t_mask();
    irqm[20] = 1'b1; pin[20] = 1'b1;
    step(2);
    chk("R7 raw set under mask", raw, 32'h10_0000);
    chk("R7 masked suppressed", msk, '0);
    chk("R7 irq suppressed", {31'd0, irq}, '0);
    irqm[20] = 1'b0;
    step();
    chk("R7 unmasked", msk, 32'h10_0000);
    chk("R9 irq on unmask", {31'd0, irq}, 32'h1);
    en[20] = 1'b0;
    step();
    chk("R8 disabled masked", msk, '0);
    chk("R8 disabled irq", {31'd0, irq}, '0);
    chk("R8 raw kept", raw, 32'h10_0000);
    en[20] = 1'b1;
    clear_all();
    step();
  endtask

  task automatic t_deb();
    edg[24] = 1'b0; deb[24] = 1'b1;
    step();
    chk("R10 debounced low", raw, '0);
    pin[24] = 1'b1;
    step(3);
    chk("R10 no tick no change", raw, '0);
    tick = 1'b1; step(); tick = 1'b0;
    step();
    chk("R10 one tick not enough", raw, '0);
    tick = 1'b1; step(); tick = 1'b0;
    step();
    chk("R10 accepted on second tick", raw, 32'h100_0000);
    pin[24] = 1'b0;
    tick = 1'b1; step(); tick = 1'b0;
    pin[24] = 1'b1;
    tick = 1'b1; step(); tick = 1'b0;
    step();
    chk("R10 glitch rejected", raw, 32'h100_0000);
    deb[24] = 1'b0;
    step();
    pin[24] = 1'b0;
    step();
    chk("R11 bypass reacts at once", raw, '0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_eoi();
    t_both();
    t_race();
    t_mask();
    t_deb();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule